// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the two wires of an I2C bus without ever driving them. It brings the clock and data lines into the system clock domain through matched synchronizer chains. It decodes the line conditions that frame a transfer and keeps a small state machine that tracks who may use the bus. A start and a repeated start are told apart by whether the bus was already claimed. A stop releases the claim. The bus is only declared free after both lines have stayed high for a timed interval, not at the moment of the stop edge.

A master front end waits for `bus_free` before it issues a start. A slave front end uses the start, repeated-start and stop pulses to reset its bit counter and address matcher. The `fast_mode` input chooses which idle interval applies. The two interval lengths are parameters counted in system clock cycles. The defaults give 4.7 µs and 1.3 µs at 200 MHz.

The state machine has three states:
- `BW_SETTLE`: the bus is not claimed but has not yet been idle long enough. This is the reset state.
- `BW_FREE`: the bus is idle and available.
- `BW_BUSY`: a transfer owns the bus.

It has these transitions:
- settle-to-free: the idle timer expires.
- settle-to-busy and free-to-busy: a start is decoded. Both report `start_pulse`.
- free-to-settle: either line goes low without a start.
- busy-to-busy: a start is decoded while busy. This reports `rstart_pulse`.
- busy-to-settle: a stop is decoded. This reports `stop_pulse`.

Top module: `i2c_bus_watch`

## Requirements
- R1: While reset is asserted and right after it is released, `bus_busy`, `bus_free`, `start_pulse`, `rstart_pulse` and `stop_pulse` are all 0.
- R2: A data-line fall while the clock line is high, when `bus_busy` is 0, gives exactly one `start_pulse`, no `rstart_pulse`, and sets `bus_busy`. This also holds right after a stop, before the bus is free.
- R3: The same data-line fall while `bus_busy` is 1 gives exactly one `rstart_pulse`, no `start_pulse`, and `bus_busy` stays 1.
- R4: A data-line rise while the clock line is high gives exactly one `stop_pulse` and clears `bus_busy`. `bus_free` stays 0 right after the stop.
- R5: Data-line changes while the clock line is low raise none of the three pulses and leave `bus_busy` unchanged.
- R6: With `fast_mode`=0, `bus_free` rises IDLE_CYC_STD+3 cycles after both lines are high at the pins. It stays 0 before then.
- R7: With `fast_mode`=1, the interval is IDLE_CYC_FAST cycles, with the same 3-cycle latency.
- R8: Either line going low before the interval ends restarts the count from zero.
- R9: When either line goes low, `bus_free` falls within 4 cycles. `bus_free` and `bus_busy` are never 1 together.
- R10: Every pulse lasts exactly one cycle, and at most one of the three pulses is high in any cycle.
- R11: Clock and data lines changing in the same cycle, both falling or both rising, raise no condition. The two synchronizer chains have equal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| fast_mode | input | 1 | 1 selects the short idle interval, 0 the long one |
| start_pulse | output | 1 | One-cycle pulse on a start while the bus is not claimed |
| rstart_pulse | output | 1 | One-cycle pulse on a start while the bus is claimed |
| stop_pulse | output | 1 | One-cycle pulse on a stop |
| bus_busy | output | 1 | Bus is claimed by a transfer |
| bus_free | output | 1 | Bus has been idle for the selected interval |

## Verification
If the state register is wrong, the error shows within one cycle of the next start decode. A start is then reported on the wrong pulse line, or `bus_busy` disagrees with the event history. A stuck or mis-reset idle counter shows at the `bus_free` edge. It either comes several cycles early or late against a count the bench derives from the pin activity, or it never rises at all. An unequal synchronizer chain or a wrong edge decode shows as a spurious pulse when both lines move in the same cycle, or when the data line toggles under a low clock.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    typedef enum logic [1:0] {
        BW_SETTLE = 2'd0,
        BW_FREE   = 2'd1,
        BW_BUSY   = 2'd2
    } bw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } line_cond_t;

    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;
    localparam int unsigned N_LINES  = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_watch_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s
);

    logic [N_LINES-1:0] raw_vec;
    logic [N_LINES-1:0] sync_vec;

    assign raw_vec[LINE_SCL] = scl_raw;
    assign raw_vec[LINE_SDA] = sda_raw;

    // Identical chains for both lines keep their latency matched
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw_vec[g]};
            end
        end
        assign sync_vec[g] = chain[STAGES-1];
    end

    assign scl_s = sync_vec[LINE_SCL];
    assign sda_s = sync_vec[LINE_SDA];

endmodule

// File: rtl/i2c_cond_decode.sv
module i2c_cond_decode
    import i2c_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    output line_cond_t cond,
    output logic       both_high
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    logic clk_held_high;
    assign clk_held_high = scl_q & scl_s;

    always_comb begin
        cond       = '0;
        cond.start = clk_held_high & sda_q & ~sda_s;
        cond.stop  = clk_held_high & ~sda_q & sda_s;
    end

    assign both_high = scl_s & sda_s;

    // R10
    cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond.start && cond.stop));

    // R5
    cond_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond.start || cond.stop) |-> $past(scl_s));

endmodule

// File: rtl/i2c_idle_timer.sv
module i2c_idle_timer #(
    parameter int unsigned IDLE_CYC_STD  = 940,
    parameter int unsigned IDLE_CYC_FAST = 260
) (
    input  logic clk,
    input  logic rst_n,
    input  logic both_high,
    input  logic fast_mode,
    output logic expired
);

    localparam int unsigned CYC_MAX = (IDLE_CYC_STD > IDLE_CYC_FAST) ? IDLE_CYC_STD : IDLE_CYC_FAST;
    localparam int unsigned CNT_W   = $clog2(CYC_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = fast_mode ? CNT_W'(IDLE_CYC_FAST) : CNT_W'(IDLE_CYC_STD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!both_high) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);

    // R8
    idle_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(both_high));

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned IDLE_CYC_STD  = 940,
    parameter int unsigned IDLE_CYC_FAST = 260
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic fast_mode,
    output logic start_pulse,
    output logic rstart_pulse,
    output logic stop_pulse,
    output logic bus_busy,
    output logic bus_free
);

    logic       scl_s;
    logic       sda_s;
    line_cond_t cond;
    logic       both_high;
    logic       idle_done;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .scl_s   (scl_s),
        .sda_s   (sda_s)
    );

    i2c_cond_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .cond      (cond),
        .both_high (both_high)
    );

    i2c_idle_timer #(
        .IDLE_CYC_STD  (IDLE_CYC_STD),
        .IDLE_CYC_FAST (IDLE_CYC_FAST)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .both_high (both_high),
        .fast_mode (fast_mode),
        .expired   (idle_done)
    );

    bw_state_e state_q;
    bw_state_e state_d;
    logic      start_d;
    logic      rstart_d;
    logic      stop_d;

    // Next-state and event logic
    always_comb begin
        state_d  = state_q;
        start_d  = 1'b0;
        rstart_d = 1'b0;
        stop_d   = cond.stop;
        unique case (state_q)
            BW_SETTLE: begin
                if (cond.start) begin
                    start_d = 1'b1;
                    state_d = BW_BUSY;
                end else if (idle_done && both_high) begin
                    state_d = BW_FREE;
                end
            end
            BW_FREE: begin
                if (cond.start) begin
                    start_d = 1'b1;
                    state_d = BW_BUSY;
                end else if (!both_high) begin
                    state_d = BW_SETTLE;
                end
            end
            BW_BUSY: begin
                if (cond.start) begin
                    rstart_d = 1'b1;
                end else if (cond.stop) begin
                    state_d = BW_SETTLE;
                end
            end
            default: state_d = BW_SETTLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BW_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse  <= 1'b0;
            rstart_pulse <= 1'b0;
            stop_pulse   <= 1'b0;
        end else begin
            start_pulse  <= start_d;
            rstart_pulse <= rstart_d;
            stop_pulse   <= stop_d;
        end
    end

    assign bus_busy = (state_q == BW_BUSY);
    assign bus_free = (state_q == BW_FREE);

    // R9
    busy_free_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_busy && bus_free));

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, rstart_pulse, stop_pulse}));

    // R10
    start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R2
    start_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (bus_busy && !$past(bus_busy)));

    // R3
    rstart_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_pulse |-> (bus_busy && $past(bus_busy)));

    // R4
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (!bus_busy && !bus_free));

endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;

    localparam int unsigned STD  = 940;
    localparam int unsigned FAST = 260;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic fast = 1'b0;
    logic start_pulse, rstart_pulse, stop_pulse, bus_busy, bus_free;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int n_rstart = 0;
    int n_stop = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    i2c_bus_watch #(
        .SYNC_STAGES   (2),
        .IDLE_CYC_STD  (STD),
        .IDLE_CYC_FAST (FAST)
    ) i_i2c_bus_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda),
        .fast_mode    (fast),
        .start_pulse  (start_pulse),
        .rstart_pulse (rstart_pulse),
        .stop_pulse   (stop_pulse),
        .bus_busy     (bus_busy),
        .bus_free     (bus_free)
    );

    // Pulse counters sampled away from the active edge
    always @(negedge clk) begin
        if (start_pulse)  n_start++;
        if (rstart_pulse) n_rstart++;
        if (stop_pulse)   n_stop++;
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic c, input logic d);
        @(negedge clk);
        scl = c;
        sda = d;
    endtask

    task automatic clr_counts;
        n_start = 0;
        n_rstart = 0;
        n_stop = 0;
    endtask

    task automatic t_reset;
        wait_cyc(1);
        eq("R1 busy in reset", int'(bus_busy), 0);
        eq("R1 free in reset", int'(bus_free), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        eq("R1 busy after reset", int'(bus_busy), 0);
        eq("R1 free after reset", int'(bus_free), 0);
        eq("R1 pulses after reset", n_start + n_rstart + n_stop, 0);
    endtask

    task automatic t_idle_std;
        fast = 1'b0;
        drive(1'b0, 1'b1);
        wait_cyc(4);
        drive(1'b1, 1'b1);
        wait_cyc(STD - 3);
        eq("R6 free before interval", int'(bus_free), 0);
        wait_cyc(8);
        eq("R6 free after interval", int'(bus_free), 1);
        // R9: clock line low drops free
        clr_counts();
        drive(1'b0, 1'b1);
        wait_cyc(4);
        eq("R9 free drops on low line", int'(bus_free), 0);
        eq("R9 busy stays low", int'(bus_busy), 0);
        drive(1'b1, 1'b1);
        wait_cyc(STD + 6);
        eq("R6 free again", int'(bus_free), 1);
        eq("R5 no event from clock toggle", n_start + n_rstart + n_stop, 0);
    endtask

    task automatic t_start;
        clr_counts();
        drive(1'b1, 1'b0);
        wait_cyc(6);
        eq("R2 start count", n_start, 1);
        eq("R2 rstart count", n_rstart, 0);
        eq("R2 busy set", int'(bus_busy), 1);
        eq("R9 free cleared by start", int'(bus_free), 0);
    endtask

    task automatic t_data;
        clr_counts();
        drive(1'b0, 1'b0); wait_cyc(3);
        drive(1'b0, 1'b1); wait_cyc(3);
        drive(1'b1, 1'b1); wait_cyc(3);
        drive(1'b0, 1'b1); wait_cyc(3);
        drive(1'b0, 1'b0); wait_cyc(3);
        drive(1'b0, 1'b1); wait_cyc(3);
        drive(1'b0, 1'b0); wait_cyc(3);
        drive(1'b1, 1'b0); wait_cyc(3);
        drive(1'b0, 1'b0); wait_cyc(6);
        eq("R5 no pulse on data bits", n_start + n_rstart + n_stop, 0);
        eq("R5 busy unchanged", int'(bus_busy), 1);
    endtask

    task automatic t_rstart;
        clr_counts();
        drive(1'b0, 1'b1); wait_cyc(3);
        drive(1'b1, 1'b1); wait_cyc(3);
        drive(1'b1, 1'b0); wait_cyc(6);
        eq("R3 rstart count", n_rstart, 1);
        eq("R3 no fresh start", n_start, 0);
        eq("R3 busy held", int'(bus_busy), 1);
    endtask

    task automatic t_stop_then_start;
        clr_counts();
        drive(1'b0, 1'b0); wait_cyc(3);
        drive(1'b1, 1'b0); wait_cyc(3);
        drive(1'b1, 1'b1); wait_cyc(6);
        eq("R4 stop count", n_stop, 1);
        eq("R10 single stop pulse", n_start + n_rstart, 0);
        eq("R4 busy cleared", int'(bus_busy), 0);
        eq("R4 not free yet", int'(bus_free), 0);
        clr_counts();
        drive(1'b1, 1'b0); wait_cyc(6);
        eq("R2 start before free", n_start, 1);
        eq("R2 not a repeated start", n_rstart, 0);
        drive(1'b0, 1'b0); wait_cyc(3);
        drive(1'b1, 1'b0); wait_cyc(3);
        clr_counts();
        drive(1'b1, 1'b1); wait_cyc(6);
        eq("R4 second stop", n_stop, 1);
    endtask

    task automatic t_timer_restart;
        // lines high since the last stop; glitch the clock line mid-interval
        wait_cyc(400);
        drive(1'b0, 1'b1); wait_cyc(1);
        drive(1'b1, 1'b1);
        wait_cyc(STD - 3);
        eq("R8 count restarted", int'(bus_free), 0);
        wait_cyc(10);
        eq("R8 free after restarted interval", int'(bus_free), 1);
    endtask

    task automatic t_fast;
        fast = 1'b1;
        drive(1'b0, 1'b1); wait_cyc(3);
        drive(1'b1, 1'b1);
        wait_cyc(FAST - 3);
        eq("R7 fast free early", int'(bus_free), 0);
        wait_cyc(8);
        eq("R7 fast free on time", int'(bus_free), 1);
    endtask

    task automatic t_skew;
        clr_counts();
        drive(1'b0, 1'b0); wait_cyc(5);
        drive(1'b1, 1'b1); wait_cyc(6);
        eq("R11 no event on joint edges", n_start + n_rstart + n_stop, 0);
        eq("R11 busy still low", int'(bus_busy), 0);
    endtask

    initial begin
        t_reset();
        t_idle_std();
        t_start();
        t_data();
        t_rstart();
        t_stop_then_start();
        t_timer_restart();
        t_fast();
        t_skew();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (!done && cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule